// File: doc/BRIEF.md
# Clocked Synchronous Serial Receive Channel

This block receives 8-bit frames over a two-wire clocked synchronous link: a serial clock supplied by the far end and a data line. Both lines are brought into the system clock domain through a short flop chain. Each rising serial clock edge shifts in one data bit, least significant bit first. When the eighth bit lands, the byte moves into a receive data register, a data-full flag goes high, and a level interrupt is raised if enabled.

The host works through three byte-wide registers. Select 0 is control: bit 0 enables reception and bit 1 enables the interrupt. Select 1 is status: bit 0 is data-full, bit 1 is overrun, bit 2 is framing error and bit 3 is parity error. Select 2 is the received byte and is read-only. A status flag clears only when software writes 0 to it after a status read has returned it as 1. A DMA acknowledge pulse clears data-full without any register write. The framing and parity error flags are set by strobe inputs from outside the block. While overrun or either error flag is set, reception halts.

To keep a stream running without loss, the host must clear data-full before the last bit of the frame in progress arrives.

Top module: `sync_rx_channel`

## Requirements
- R1: Data bits are taken on each rising serial clock edge, least significant bit first. After the eighth edge, the data register (select 2) holds the byte and status bit 0 (data-full) reads 1.
- R2: `irq_o` is high exactly while data-full is 1 and control bit 1 (interrupt enable) is 1, so every rise of data-full raises it.
- R3: If a frame completes while data-full is 1, status bit 1 (overrun) sets and the data register keeps its previous byte.
- R4: While overrun is 1, completed frames are discarded: data-full stays 0 and the data register is unchanged. After overrun is cleared, frames are accepted again.
- R5: `frm_err_set_i` sets status bit 2 and `par_err_set_i` sets status bit 3. While either flag is 1, data-full never sets and no byte is transferred.
- R6: A status flag clears only on a status write with that bit 0, after a status read returned the flag as 1. A write of 0 without that prior read, or a write of 1, leaves the flag unchanged.
- R7: A pulse on `dma_rd_ack_i` clears data-full on the next clock.
- R8: While control bit 0 (receive enable) is 0, serial edges are ignored and any partly received frame is discarded. The next enabled frame starts from bit 0.
- R9: After reset, control, status and data all read 0 and `irq_o` is 0.
- R10: If data-full is cleared before the eighth bit of the next frame arrives, that frame is accepted with no overrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Serial clock from the far end |
| sdata_i | input | 1 | Serial data line |
| reg_sel_i | input | 2 | Register select: 0 control, 1 status, 2 data |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe (a status read arms flag clearing) |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Contents of the selected register |
| frm_err_set_i | input | 1 | Strobe that sets the framing error flag |
| par_err_set_i | input | 1 | Strobe that sets the parity error flag |
| dma_rd_ack_i | input | 1 | DMA has read the data register; clears data-full |
| irq_o | output | 1 | Receive interrupt level |

## Verification
A wrong bit count or bit order shows up at the data register, which is readable within a few clocks of the eighth serial edge. A stale data-full flag or a missed overrun shows on the very next completed frame: overrun status is wrong and the data register holds the wrong byte. A broken flag arming rule shows up in the status read after a single software write. Gating faults show as data-full rising during an error or disabled period, so the bench reads status after every frame sent under those conditions.

// File: rtl/sync_rx_pkg.sv
package sync_rx_pkg;
  localparam int SEL_W   = 2;
  localparam int NFLAG   = 4;
  localparam int CTRL_W  = 2;

  typedef enum logic [SEL_W-1:0] {
    SEL_CTRL = 2'd0,
    SEL_STAT = 2'd1,
    SEL_DATA = 2'd2
  } reg_sel_e;

  localparam int FL_FULL = 0;
  localparam int FL_OVR  = 1;
  localparam int FL_FER  = 2;
  localparam int FL_PER  = 3;

  localparam int CT_RXEN  = 0;
  localparam int CT_IRQEN = 1;
endpackage

// File: rtl/sync_rx_edge.sv
module sync_rx_edge #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sclk_i,
  input  logic sdata_i,
  output logic sdata_o,
  output logic rise_o
);
  logic [1:0] pipe_q [STAGES];
  logic       prev_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pipe_q[g] <= '0;
      else if (g == 0) pipe_q[g] <= {sclk_i, sdata_i};
      else pipe_q[g] <= pipe_q[(g == 0) ? 0 : g-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else prev_q <= pipe_q[STAGES-1][1];
  end

  assign sdata_o = pipe_q[STAGES-1][0];
  assign rise_o  = pipe_q[STAGES-1][1] & ~prev_q;
endmodule

// File: rtl/sync_rx_shift.sv
module sync_rx_shift #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              active_i,
  input  logic              rise_i,
  input  logic              bit_i,
  output logic              done_o,
  output logic [DATA_W-1:0] byte_o
);
  localparam int CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W-1);

  logic [DATA_W-1:0] sh_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              take;

  assign take   = active_i & rise_i;
  assign done_o = take & (cnt_q == LAST);
  assign byte_o = {bit_i, sh_q[DATA_W-1:1]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (!active_i) begin
      cnt_q <= '0;  // partial frame discarded
    end else if (take) begin
      sh_q  <= byte_o;
      cnt_q <= done_o ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/sync_rx_regs.sv
module sync_rx_regs
  import sync_rx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [SEL_W-1:0]  reg_sel_i,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic              frame_done_i,
  input  logic [DATA_W-1:0] frame_byte_i,
  input  logic              dma_ack_i,
  input  logic              fer_set_i,
  input  logic              per_set_i,
  output logic              rx_en_o,
  output logic              irq_en_o,
  output logic [NFLAG-1:0]  flags_o,
  output logic [DATA_W-1:0] data_o
);
  logic [CTRL_W-1:0] ctrl_q;
  logic [NFLAG-1:0]  flag_q, arm_q, set_v, clr_v;
  logic [DATA_W-1:0] data_q;
  logic              stat_wr, stat_rd;

  assign stat_wr = reg_wr_i & (reg_sel_i == SEL_STAT);
  assign stat_rd = reg_rd_i & (reg_sel_i == SEL_STAT);

  always_comb begin
    set_v          = '0;
    set_v[FL_FULL] = frame_done_i & ~flag_q[FL_FULL];
    set_v[FL_OVR]  = frame_done_i &  flag_q[FL_FULL];
    set_v[FL_FER]  = fer_set_i;
    set_v[FL_PER]  = per_set_i;
  end

  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    logic hw_clr;
    if (i == FL_FULL) begin : g_dma
      assign hw_clr = dma_ack_i;
    end else begin : g_nodma
      assign hw_clr = 1'b0;
    end
    assign clr_v[i] = hw_clr | (stat_wr & ~reg_wdata_i[i] & arm_q[i]);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        flag_q[i] <= 1'b0;
        arm_q[i]  <= 1'b0;
      end else begin
        flag_q[i] <= set_v[i] | (flag_q[i] & ~clr_v[i]);
        if (!flag_q[i] || clr_v[i]) arm_q[i] <= 1'b0;
        else if (stat_rd)           arm_q[i] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      data_q <= '0;
    end else begin
      if (reg_wr_i && reg_sel_i == SEL_CTRL) ctrl_q <= reg_wdata_i[CTRL_W-1:0];
      if (set_v[FL_FULL]) data_q <= frame_byte_i;
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_sel_i)
      SEL_CTRL: reg_rdata_o[CTRL_W-1:0] = ctrl_q;
      SEL_STAT: reg_rdata_o[NFLAG-1:0]  = flag_q;
      SEL_DATA: reg_rdata_o             = data_q;
      default:  reg_rdata_o             = '0;
    endcase
  end

  assign rx_en_o  = ctrl_q[CT_RXEN];
  assign irq_en_o = ctrl_q[CT_IRQEN];
  assign flags_o  = flag_q;
  assign data_o   = data_q;
endmodule

// File: rtl/sync_rx_channel.sv
module sync_rx_channel
  import sync_rx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              sdata_i,
  input  logic [SEL_W-1:0]  reg_sel_i,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic              frm_err_set_i,
  input  logic              par_err_set_i,
  input  logic              dma_rd_ack_i,
  output logic              irq_o
);
  logic              sd_w, rise_w, active_w, frame_done_w;
  logic              rx_en_w, irq_en_w;
  logic [NFLAG-1:0]  flags_w;
  logic [DATA_W-1:0] byte_w, data_w;

  sync_rx_edge #(.STAGES(SYNC_STAGES)) u_edge (
    .clk_i, .rst_ni, .sclk_i, .sdata_i,
    .sdata_o(sd_w), .rise_o(rise_w)
  );

  // reception halts on disable or any sticky error
  assign active_w = rx_en_w & ~flags_w[FL_OVR] & ~flags_w[FL_FER] & ~flags_w[FL_PER];

  sync_rx_shift #(.DATA_W(DATA_W)) u_shift (
    .clk_i, .rst_ni,
    .active_i(active_w), .rise_i(rise_w), .bit_i(sd_w),
    .done_o(frame_done_w), .byte_o(byte_w)
  );

  sync_rx_regs #(.DATA_W(DATA_W)) u_regs (
    .clk_i, .rst_ni,
    .reg_sel_i, .reg_wr_i, .reg_rd_i, .reg_wdata_i, .reg_rdata_o,
    .frame_done_i(frame_done_w), .frame_byte_i(byte_w),
    .dma_ack_i(dma_rd_ack_i), .fer_set_i(frm_err_set_i), .per_set_i(par_err_set_i),
    .rx_en_o(rx_en_w), .irq_en_o(irq_en_w), .flags_o(flags_w), .data_o(data_w)
  );

  assign irq_o = flags_w[FL_FULL] & irq_en_w;
endmodule

// File: rtl/sync_rx_chk.sv
module sync_rx_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              irq_o,
  input logic              full,
  input logic              ovr,
  input logic              fer,
  input logic              per,
  input logic              rx_en,
  input logic              irq_en,
  input logic              frame_done,
  input logic              dma_ack,
  input logic [DATA_W-1:0] data
);
  AST_FULL_FROM_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(full) |-> $past(frame_done)); // R1
  AST_IRQ_WHEN_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full && irq_en) |-> irq_o); // R2
  AST_OVR_KEEPS_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_done && full) |=> (ovr && $stable(data))); // R3
  AST_NO_RX_IN_OVR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovr && !full) |=> !full); // R4
  AST_NO_FULL_ON_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((fer || per) && !full) |=> !full); // R5
  AST_DMA_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_ack |=> !full); // R7
  AST_DONE_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done |-> (rx_en && !ovr && !fer && !per)); // R8
endmodule

bind sync_rx_channel sync_rx_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .irq_o(irq_o),
  .full(flags_w[0]), .ovr(flags_w[1]), .fer(flags_w[2]), .per(flags_w[3]),
  .rx_en(rx_en_w), .irq_en(irq_en_w), .frame_done(frame_done_w),
  .dma_ack(dma_rd_ack_i), .data(data_w)
);

// File: tb/sync_rx_channel_tb_top.sv
module sync_rx_channel_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sclk = 1'b0, sdata = 1'b0;
  logic [1:0] sel = '0;
  logic       wr = 1'b0, rd = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       fer_set = 1'b0, per_set = 1'b0, dma_ack = 1'b0;
  logic       irq;
  int         total = 0, bad = 0;

  always #5 clk = ~clk;

  sync_rx_channel dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .sdata_i(sdata),
    .reg_sel_i(sel), .reg_wr_i(wr), .reg_rd_i(rd), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .frm_err_set_i(fer_set), .par_err_set_i(per_set),
    .dma_rd_ack_i(dma_ack), .irq_o(irq)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  task automatic reg_write(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk); sel = s; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] s, output logic [7:0] d);
    @(negedge clk); sel = s; rd = 1'b1; #1 d = rdata;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk); sdata = b; sclk = 1'b0;
    repeat (3) @(negedge clk);
    sclk = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] b);
    for (int i = 0; i < 8; i++) send_bit(b[i]);
    sclk = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic clear_status(input logic [7:0] keep);
    logic [7:0] s;
    reg_read(2'd1, s);
    reg_write(2'd1, keep);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    reg_read(2'd0, v); check("R9 ctrl", v, 0);
    reg_read(2'd1, v); check("R9 status", v, 0);
    reg_read(2'd2, v); check("R9 data", v, 0);
    check("R9 irq", irq, 0);
  endtask

  task automatic t_basic();
    logic [7:0] v;
    reg_write(2'd0, 8'h03);
    send_byte(8'hA5);
    reg_read(2'd2, v); check("R1 data", v, 8'hA5);
    reg_read(2'd1, v); check("R1 full", v, 8'h01);
    check("R2 irq high", irq, 1);
    reg_write(2'd1, 8'h00);
    reg_read(2'd1, v); check("R6 cleared after read", v, 8'h00);
    check("R2 irq low", irq, 0);
    reg_write(2'd0, 8'h01);
    send_byte(8'h3C);
    check("R2 irq masked", irq, 0);
    reg_write(2'd0, 8'h03);
    check("R2 irq unmasked", irq, 1);
    clear_status(8'h00);
  endtask

  task automatic t_write_rules();
    logic [7:0] v;
    send_byte(8'h96);
    reg_write(2'd1, 8'h00);
    reg_read(2'd1, v); check("R6 write0 without read", v, 8'h01);
    reg_write(2'd1, 8'hFF);
    reg_read(2'd1, v); check("R6 write1 no effect", v, 8'h01);
    reg_write(2'd1, 8'h00);
    reg_read(2'd1, v); check("R6 write0 after read", v, 8'h00);
  endtask

  task automatic t_overrun();
    logic [7:0] v;
    send_byte(8'h11);
    send_byte(8'h22);
    reg_read(2'd1, v); check("R3 overrun set", v, 8'h03);
    reg_read(2'd2, v); check("R3 data kept", v, 8'h11);
    reg_write(2'd1, 8'h02);
    reg_read(2'd1, v); check("R4 overrun stays", v, 8'h02);
    send_byte(8'h33);
    reg_read(2'd1, v); check("R4 no full in overrun", v, 8'h02);
    reg_read(2'd2, v); check("R4 data unchanged", v, 8'h11);
    reg_write(2'd1, 8'h00);
    send_byte(8'h44);
    reg_read(2'd1, v); check("R4 resumed status", v, 8'h01);
    reg_read(2'd2, v); check("R4 resumed data", v, 8'h44);
  endtask

  task automatic t_dma();
    logic [7:0] v;
    @(negedge clk); dma_ack = 1'b1;
    @(negedge clk); dma_ack = 1'b0;
    reg_read(2'd1, v); check("R7 dma clears full", v, 8'h00);
    check("R7 irq low", irq, 0);
  endtask

  task automatic t_continuity();
    logic [7:0] v;
    send_byte(8'h5A);
    for (int i = 0; i < 7; i++) send_bit(1'(8'hC3 >> i));
    clear_status(8'h00);
    send_bit(1'b1);
    sclk = 1'b0;
    repeat (4) @(negedge clk);
    reg_read(2'd1, v); check("R10 no overrun", v, 8'h01);
    reg_read(2'd2, v); check("R10 next byte", v, 8'hC3);
    clear_status(8'h00);
  endtask

  task automatic t_errors();
    logic [7:0] v;
    @(negedge clk); fer_set = 1'b1;
    @(negedge clk); fer_set = 1'b0;
    reg_read(2'd1, v); check("R5 fer flag", v, 8'h04);
    send_byte(8'h77);
    reg_read(2'd1, v); check("R5 no full with fer", v, 8'h04);
    reg_read(2'd2, v); check("R5 data held fer", v, 8'hC3);
    reg_write(2'd1, 8'h00);
    @(negedge clk); per_set = 1'b1;
    @(negedge clk); per_set = 1'b0;
    reg_read(2'd1, v); check("R5 per flag", v, 8'h08);
    send_byte(8'h78);
    reg_read(2'd1, v); check("R5 no full with per", v, 8'h08);
    reg_write(2'd1, 8'h00);
    send_byte(8'h79);
    reg_read(2'd2, v); check("R5 resumed data", v, 8'h79);
    clear_status(8'h00);
  endtask

  task automatic t_disable();
    logic [7:0] v;
    reg_write(2'd0, 8'h02);
    send_byte(8'hE1);
    reg_read(2'd1, v); check("R8 disabled no full", v, 8'h00);
    reg_write(2'd0, 8'h03);
    for (int i = 0; i < 3; i++) send_bit(1'b1);
    sclk = 1'b0;
    reg_write(2'd0, 8'h02);
    reg_write(2'd0, 8'h03);
    send_byte(8'h9A);
    reg_read(2'd2, v); check("R8 partial discarded", v, 8'h9A);
    reg_read(2'd1, v); check("R8 full after enable", v, 8'h01);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_basic();
    t_write_rules();
    t_overrun();
    t_dma();
    t_continuity();
    t_errors();
    t_disable();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule